// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block produces the processor reset for a supply supervisor. It receives three comparator flags from analog circuits outside the block: supply below the reset threshold, supply below the backup battery, and the power-fail input below its reference. It also receives a one-cycle watchdog expiry strobe and a time base. Any supply fault or watchdog expiry asserts the reset. Once every trigger has gone away, the reset stays asserted until a parameterised number of time-base ticks has been counted.

The time base comes from one of two sources. It is either a tick strobe from an internal oscillator divider, or the rising edges of a slow external clock. A strap input selects the source.

The block also produces several side outputs:
- a low-line flag that follows the threshold comparator with no stretching;
- a chip-enable output that blocks memory access while the supply is low;
- a power-fail output that is forced active while the part runs from the battery.

Every comparator flag and the external clock pass through two-flop synchronizers. The block reset is asserted asynchronously and released synchronously.

Top module: `sup_rst_gen`

## Requirements
- R1: While `rst_n` is low, the outputs are `rst_out_n`=0, `rst_out`=1, `low_line_n`=0, `ce_out_n`=1 and `pfo_n`=0. The internal reset is released on the second clock edge after `rst_n` rises.
- R2: A synchronized below-threshold flag or below-battery flag (1 = fault) asserts the reset (`rst_out_n`=0) on the next clock edge, and keeps it asserted while the flag stays set.
- R3: Once no trigger is present, the reset deasserts on the clock edge that consumes the HOLD_TICKS-th tick of the selected time base. No other edge releases it.
- R4: A `wd_expire` strobe asserts the reset on the next edge and reloads the full hold count, also when it arrives during an active pulse.
- R5: `rst_out` is always the logical inverse of `rst_out_n`.
- R6: `low_line_n` is the inverse of the synchronized below-threshold flag, with no stretching.
- R7: `ce_out_n` equals `ce_in_n` (a combinational path) while the synchronized below-threshold flag is 0. It is forced to 1 while that flag is 1.
- R8: `pfo_n` is the inverse of the synchronized power-fail flag, and is forced to 0 while the synchronized below-battery flag is 1.
- R9: With `osc_int_sel`=1 the tick is the `int_tick` strobe. With `osc_int_sel`=0 the tick is each synchronized rising edge of `ext_osc_a`, and `int_tick` is ignored.
- R10: Each asynchronous input (the three flags and `ext_osc_a`) passes through two flops, so a change first affects the outputs after the second clock edge.
- R11: A trigger in the same cycle as a tick reloads the count; the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_low_a | input | 1 | Supply below reset threshold (async, 1 = fault) |
| batt_low_a | input | 1 | Supply below battery (async, 1 = fault) |
| pf_low_a | input | 1 | Power-fail input below reference (async, 1 = low) |
| ext_osc_a | input | 1 | External time-base clock (async) |
| osc_int_sel | input | 1 | 1 = internal tick strobe, 0 = external clock edges |
| int_tick | input | 1 | Internal time-base tick strobe (synchronous) |
| wd_expire | input | 1 | Watchdog timeout strobe (synchronous) |
| ce_in_n | input | 1 | Chip-enable request, active low |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| low_line_n | output | 1 | Low-line flag, active low |
| ce_out_n | output | 1 | Gated chip-enable, active low |
| pfo_n | output | 1 | Power-fail output, active low |

## Verification
Results fall due at different times after a stimulus:
- A flag change reaches `low_line_n`, `ce_out_n` and `pfo_n` after the second clock edge.
- A flag change reaches `rst_out_n` after the third edge.
- A `wd_expire` strobe shows on `rst_out_n` after the first edge.
- An external clock rise is counted on the third edge.

The bench model keeps explicit two-deep delay lines for every asynchronous input and updates itself at each rising edge. Inputs change just after the falling edge, and every output is compared at the next falling edge. Each result is therefore checked in the exact cycle it is due, no earlier and no later.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef struct packed {
    logic ext_osc;
    logic pf_low;
    logic batt_low;
    logic thr_low;
  } sup_flags_t;

  localparam int FLAG_W = $bits(sup_flags_t);
  // Reset state assumes a faulty supply and a quiet external clock.
  localparam sup_flags_t FLAGS_RST = '{ext_osc: 1'b0, pf_low: 1'b1,
                                       batt_low: 1'b1, thr_low: 1'b1};
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_a;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sup_tick_sel.sv
module sup_tick_sel (
  input  logic clk,
  input  logic rst_ni,
  input  logic sel_int,
  input  logic int_tick,
  input  logic ext_s,
  output logic tick
);
  logic ext_prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ext_prev_q <= 1'b0;
    else         ext_prev_q <= ext_s;
  end

  always_comb begin
    if (sel_int) tick = int_tick;
    else         tick = ext_s & ~ext_prev_q;
  end
endmodule

// File: rtl/sup_hold_ctr.sv
module sup_hold_ctr #(
  parameter int HOLD_TICKS = 12,
  localparam int CNT_W     = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic trig,
  input  logic tick,
  output logic active
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_TICKS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    act_d  = act_q;
    if (trig) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD;
      act_d  = 1'b1;
    end else if (act_q && tick) begin
      cnt_en = 1'b1;
      if (cnt_q == ONE) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD;
      act_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen
  import sup_pkg::*;
#(
  parameter int HOLD_TICKS  = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_low_a,
  input  logic batt_low_a,
  input  logic pf_low_a,
  input  logic ext_osc_a,
  input  logic osc_int_sel,
  input  logic int_tick,
  input  logic wd_expire,
  input  logic ce_in_n,
  output logic rst_out_n,
  output logic rst_out,
  output logic low_line_n,
  output logic ce_out_n,
  output logic pfo_n
);
  logic [1:0] rsync_q;
  logic       rst_ni;
  sup_flags_t flg_a, flg_s;
  logic       thr_s, batt_s, pf_s, ext_s;
  logic       tick, trig, active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  always_comb begin
    flg_a.thr_low  = thr_low_a;
    flg_a.batt_low = batt_low_a;
    flg_a.pf_low   = pf_low_a;
    flg_a.ext_osc  = ext_osc_a;
  end

  sup_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES), .RST_VAL(FLAGS_RST)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .d_a(flg_a), .q(flg_s)
  );

  assign thr_s  = flg_s.thr_low;
  assign batt_s = flg_s.batt_low;
  assign pf_s   = flg_s.pf_low;
  assign ext_s  = flg_s.ext_osc;

  sup_tick_sel u_tick (
    .clk(clk), .rst_ni(rst_ni), .sel_int(osc_int_sel),
    .int_tick(int_tick), .ext_s(ext_s), .tick(tick)
  );

  assign trig = thr_s | batt_s | wd_expire;

  sup_hold_ctr #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_ni(rst_ni), .trig(trig), .tick(tick), .active(active)
  );

  assign rst_out_n  = ~active;
  assign rst_out    = active;
  assign low_line_n = ~thr_s;
  assign ce_out_n   = ce_in_n | thr_s;
  assign pfo_n      = ~(pf_s | batt_s);
endmodule

// File: rtl/sup_rst_gen_chk.sv
module sup_rst_gen_chk (
  input logic clk,
  input logic rst_ni,
  input logic thr_s,
  input logic batt_s,
  input logic tick,
  input logic wd_expire,
  input logic rst_out_n,
  input logic rst_out,
  input logic ce_out_n,
  input logic pfo_n
);
  p_fault_asserts_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (thr_s || batt_s) |=> !rst_out_n);

  p_release_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rst_out_n) |-> ($past(tick) && !$past(thr_s || batt_s || wd_expire)));

  p_wd_asserts_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    wd_expire |=> !rst_out_n);

  p_complement_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_out != rst_out_n);

  p_ce_blocked_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    thr_s |-> ce_out_n);

  p_pfo_forced_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    batt_s |-> !pfo_n);
endmodule

bind sup_rst_gen sup_rst_gen_chk u_chk (
  .clk(clk), .rst_ni(rst_ni), .thr_s(thr_s), .batt_s(batt_s), .tick(tick),
  .wd_expire(wd_expire), .rst_out_n(rst_out_n), .rst_out(rst_out),
  .ce_out_n(ce_out_n), .pfo_n(pfo_n)
);

// File: tb/sup_rst_gen_test.sv
module sup_rst_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic rst_n, thr, batt, pf, ext_osc, osc_sel, int_tick, wd, ce_in_n;
  logic rst_out_n, rst_out, low_line_n, ce_out_n, pfo_n;

  int errors = 0, checks = 0, cyc = 0;
  bit int_en = 1'b1, started = 1'b0, done = 1'b0;

  // behavioural reference state
  int m_r1, m_r2, m_act, m_cnt;
  int t_q[2], b_q[2], p_q[2], e_q[3];

  always #(CLK_PERIOD/2) clk = ~clk;

  sup_rst_gen #(.HOLD_TICKS(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .thr_low_a(thr), .batt_low_a(batt),
    .pf_low_a(pf), .ext_osc_a(ext_osc), .osc_int_sel(osc_sel),
    .int_tick(int_tick), .wd_expire(wd), .ce_in_n(ce_in_n),
    .rst_out_n(rst_out_n), .rst_out(rst_out), .low_line_n(low_line_n),
    .ce_out_n(ce_out_n), .pfo_n(pfo_n)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_act = 1; m_cnt = HOLD;
      t_q = '{1, 1}; b_q = '{1, 1}; p_q = '{1, 1}; e_q = '{0, 0, 0};
      started = 1'b1;
    end else if (m_r2 == 0) begin
      m_r2 = m_r1; m_r1 = 1;
    end else begin
      int bad, tk;
      bad = t_q[1] | b_q[1];
      tk  = osc_sel ? int'(int_tick) : (e_q[1] & ~e_q[2]);
      if (bad != 0 || wd) begin
        m_act = 1; m_cnt = HOLD;
      end else if (m_act != 0 && tk != 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_act = 0;
      end
      e_q[2] = e_q[1]; e_q[1] = e_q[0]; e_q[0] = int'(ext_osc);
      t_q[1] = t_q[0]; t_q[0] = int'(thr);
      b_q[1] = b_q[0]; b_q[0] = int'(batt);
      p_q[1] = p_q[0]; p_q[0] = int'(pf);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      int e_rst, e_ll, e_ce, e_pf;
      e_rst = (m_act != 0) ? 0 : 1;
      e_ll  = (t_q[1] != 0) ? 0 : 1;
      e_ce  = (t_q[1] != 0) ? 1 : int'(ce_in_n);
      e_pf  = (b_q[1] != 0 || p_q[1] != 0) ? 0 : 1;
      if (!rst_n) begin
        chk(rst_out_n == 0 && rst_out == 1 && low_line_n == 0 && ce_out_n == 1
            && pfo_n == 0, "R1 reset state", int'(rst_out_n), 0);
      end else begin
        chk(int'(rst_out_n) == e_rst, "R2 R3 R4 R9 R10 R11 rst_out_n", int'(rst_out_n), e_rst);
        chk(rst_out == !rst_out_n, "R5 rst_out", int'(rst_out), int'(!rst_out_n));
        chk(int'(low_line_n) == e_ll, "R6 R10 low_line_n", int'(low_line_n), e_ll);
        chk(int'(ce_out_n) == e_ce, "R7 ce_out_n", int'(ce_out_n), e_ce);
        chk(int'(pfo_n) == e_pf, "R8 pfo_n", int'(pfo_n), e_pf);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      cyc++;
      int_tick = int_en && (cyc % 3 == 0);
      ext_osc  = ((cyc / 4) % 2) != 0;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; thr = 1'b1; batt = 1'b1; pf = 1'b1; ext_osc = 1'b0;
    osc_sel = 1'b1; int_tick = 1'b0; wd = 1'b0; ce_in_n = 1'b0;
    step(4);
    rst_n = 1'b1; step(5);            // R1 release, R2 hold while faulted
    thr = 1'b0; batt = 1'b0; pf = 1'b0;
    step(50);                          // R3 power-on hold via internal ticks
    ce_in_n = 1'b1; step(2); ce_in_n = 1'b0; step(2);   // R7 pass-through
    wd = 1'b1; step(1); wd = 1'b0; step(15);            // R4 pulse
    wd = 1'b1; step(1); wd = 1'b0; step(45);            // R4 restart mid-pulse
    thr = 1'b1; ce_in_n = 1'b1; step(3); ce_in_n = 1'b0; step(3);  // R6 R7
    thr = 1'b0; step(50);
    batt = 1'b1; step(6); batt = 1'b0; step(50);        // R2 R8
    pf = 1'b1; step(5); pf = 1'b0; step(3);             // R8
    osc_sel = 1'b0; wd = 1'b1; step(1); wd = 1'b0;      // R9 external base
    step(120);
    osc_sel = 1'b1;
    for (int k = 0; k < 6; k++) begin                    // R11 trigger vs tick
      wd = 1'b1; step(1); wd = 1'b0; step(1);
    end
    step(50);
    int_en = 1'b0; wd = 1'b1; step(1); wd = 1'b0; step(20);  // no ticks: held
    int_en = 1'b1; step(45);
    finish_run();
  end
endmodule